// File: doc/BRIEF.md
# Event-Controlled Counter Action Unit

This block sits between two asynchronous event lines and the core of a timer counter. Each event line is first brought into the clock domain by a synchroniser chain. A registered copy of the synchronised level then gives a rising-edge strobe and a falling-edge strobe. Two static selector inputs decide what the events do. The primary selector chooses between four actions: counting rising edges, counting edges of either polarity, gating the prescaled tick with the event level, or counting prescaled ticks with the event level choosing the direction. The secondary selector can leave the counter alone, steer the direction from the second line, or request a restart. A restart can be triggered by a rising edge or by any edge, or it can be held for as long as the line stays high.

The outputs go straight to the counter core. They are a one-cycle count strobe, a direction level and a restart request. A restart always overrides a count step in the same cycle, so the counter reads zero after that cycle. The outputs are combinational from the synchroniser state, the prescaler tick and the selectors, so a prescaler tick is acted on in the cycle in which it arrives.

Top module: `evact_unit`

## Requirements
- R1: An event line change affects the outputs only after two rising clock edges, which is the synchroniser latency (SYNC_STAGES = 2). An edge strobe lasts exactly one cycle.
- R2: With act_a_sel = 0 and no direction mode, cnt_tick pulses for one cycle on each rising edge of ev_a_in. A falling edge produces no pulse, and a steady level produces none either.
- R3: With act_a_sel = 1, cnt_tick pulses for one cycle on every rising edge and on every falling edge of ev_a_in.
- R4: With act_a_sel = 2, cnt_tick equals presc_tick while the synchronised ev_a_in is 1, and is 0 while it is 0.
- R5: With act_a_sel = 3, cnt_tick equals presc_tick and cnt_down equals the synchronised ev_a_in (1 = count down, 0 = count up).
- R6: With act_b_sel = 3, cnt_tick equals presc_tick and cnt_down equals the synchronised ev_b_in, whatever act_a_sel says. Outside act_b_sel = 3 and act_a_sel = 3, cnt_down is 0.
- R7: With act_b_sel = 4, cnt_restart pulses for one cycle on each rising edge of ev_b_in. A falling edge gives no pulse.
- R8: With act_b_sel = 5, cnt_restart pulses for one cycle on every edge of ev_b_in.
- R9: With act_b_sel = 6, cnt_restart is 1 for as long as the synchronised ev_b_in is 1.
- R10: act_b_sel values 0, 1, 2 and 7 never raise cnt_restart and leave cnt_tick and cnt_down as act_a_sel defines them.
- R11: In any cycle where cnt_restart is 1, cnt_tick is 0 (restart has priority).
- R12: While rst_n is low, cnt_tick and cnt_restart are 0, and the synchroniser and edge state are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| ev_a_in | input | 1 | Primary asynchronous event line |
| ev_b_in | input | 1 | Secondary asynchronous event line |
| presc_tick | input | 1 | One-cycle prescaled clock tick |
| act_a_sel | input | 2 | Primary action: 0 rise count, 1 any-edge count, 2 level gate, 3 up/down |
| act_b_sel | input | 3 | Secondary action: 0 none, 3 up/down, 4 restart on rise, 5 restart on any edge, 6 restart hold; 1, 2, 7 none |
| cnt_tick | output | 1 | Count one step this cycle |
| cnt_down | output | 1 | Direction for the step, 1 = down |
| cnt_restart | output | 1 | Restart the counter this cycle |

## Verification
A vector table sweeps the level-driven actions with settled event levels, with the prescaler tick both high and low. This separates gating by level from plain tick passing, and it shows which channel wins the direction when both selectors ask for up/down. Directed sequences then drive single rising and falling transitions on each line under each edge-driven code. They count the clock edges before a strobe appears, which separates rise-only detection from any-edge detection and checks that each strobe is one cycle wide. A simultaneous count edge and restart edge shows that restart wins. Edges applied under the unused secondary codes confirm those codes stay silent.

// File: rtl/evact_pkg.sv
package evact_pkg;

  // Primary action selector codes
  localparam logic [1:0] A_CNT_RISE = 2'd0;
  localparam logic [1:0] A_CNT_ANY  = 2'd1;
  localparam logic [1:0] A_GATE_LVL = 2'd2;
  localparam logic [1:0] A_UPDOWN   = 2'd3;

  // Secondary action selector codes (1, 2, 7 unused -> no action)
  localparam logic [2:0] B_NONE     = 3'd0;
  localparam logic [2:0] B_UPDOWN   = 3'd3;
  localparam logic [2:0] B_RST_RISE = 3'd4;
  localparam logic [2:0] B_RST_ANY  = 3'd5;
  localparam logic [2:0] B_RST_HOLD = 3'd6;

  // Synchronised view of one event line
  typedef struct packed {
    logic level;
    logic rise;
    logic fall;
  } ev_view_t;

  // Edge selection: rising only, or either polarity
  function automatic logic edge_hit(input logic any_pol, input ev_view_t v);
    return v.rise | (any_pol & v.fall);
  endfunction

  // Level gating of the prescaled tick
  function automatic logic gated_tick(input logic tick, input logic lvl);
    return tick & lvl;
  endfunction

  // Restart wins over a count step
  function automatic logic resolve_tick(input logic tick_req, input logic rst_req);
    return tick_req & ~rst_req;
  endfunction

  // Secondary code that restarts on an edge
  function automatic logic b_is_edge_restart(input logic [2:0] code);
    return (code == B_RST_RISE) || (code == B_RST_ANY);
  endfunction

endpackage

// File: rtl/evact_sync_edge.sv
module evact_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output evact_pkg::ev_view_t view
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;
  logic          prev_lvl;
  logic          lvl;

  generate
    if (STAGES < 2) begin : g_bad_depth
      initial $error("evact_sync_edge: STAGES must be at least 2");
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain    <= '0;
      prev_lvl <= 1'b0;
    end else begin
      chain    <= {chain[LAST-1:0], async_in};
      prev_lvl <= chain[LAST];
    end
  end

  assign lvl        = chain[LAST];
  assign view.level = lvl;
  assign view.rise  = lvl & ~prev_lvl;
  assign view.fall  = ~lvl & prev_lvl;

  // Edge strobes last a single cycle
  assert_rise_one_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    view.rise |=> !view.rise);
  assert_fall_one_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    view.fall |=> !view.fall);
  // After a rising strobe the level stays high or produces a falling strobe
  assert_rise_then_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
    view.rise |=> (view.level || view.fall));

endmodule

// File: rtl/evact_decode_a.sv
module evact_decode_a (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          code,
  input  evact_pkg::ev_view_t ev,
  input  logic                presc_tick,
  output logic                tick_req,
  output logic                dir_valid,
  output logic                dir_down
);
  import evact_pkg::*;

  always_comb begin
    tick_req  = 1'b0;
    dir_valid = 1'b0;
    dir_down  = 1'b0;
    unique case (code)
      A_CNT_RISE: tick_req = edge_hit(1'b0, ev);
      A_CNT_ANY:  tick_req = edge_hit(1'b1, ev);
      A_GATE_LVL: tick_req = gated_tick(presc_tick, ev.level);
      A_UPDOWN: begin
        tick_req  = presc_tick;
        dir_valid = 1'b1;
        dir_down  = ev.level;
      end
      default: tick_req = 1'b0;
    endcase
  end

  assert_gate_closed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (code == A_GATE_LVL && !ev.level) |-> !tick_req);
  assert_rise_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (code == A_CNT_RISE && ev.fall) |-> !tick_req);
  assert_no_tick_without_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (code == A_CNT_ANY && !ev.rise && !ev.fall) |-> !tick_req);

endmodule

// File: rtl/evact_decode_b.sv
module evact_decode_b (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          code,
  input  evact_pkg::ev_view_t ev,
  output logic                restart_req,
  output logic                updn_on,
  output logic                dir_down
);
  import evact_pkg::*;

  always_comb begin
    restart_req = 1'b0;
    updn_on     = 1'b0;
    dir_down    = 1'b0;
    case (code)
      B_UPDOWN: begin
        updn_on  = 1'b1;
        dir_down = ev.level;
      end
      B_RST_RISE: restart_req = edge_hit(1'b0, ev);
      B_RST_ANY:  restart_req = edge_hit(1'b1, ev);
      B_RST_HOLD: restart_req = ev.level;
      default:    restart_req = 1'b0;
    endcase
  end

  assert_unused_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (code == 3'd0 || code == 3'd1 || code == 3'd2 || code == 3'd7) |-> !restart_req);
  assert_hold_tracks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (code == B_RST_HOLD && ev.level) |-> restart_req);
  assert_edge_restart_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (b_is_edge_restart(code) && restart_req && $stable(code)) |=> !restart_req);

endmodule

// File: rtl/evact_unit.sv
module evact_unit #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_a_in,
  input  logic       ev_b_in,
  input  logic       presc_tick,
  input  logic [1:0] act_a_sel,
  input  logic [2:0] act_b_sel,
  output logic       cnt_tick,
  output logic       cnt_down,
  output logic       cnt_restart
);
  import evact_pkg::*;

  localparam int N_EV = 2;
  localparam int CH_A = 0;
  localparam int CH_B = 1;

  logic [N_EV-1:0] ev_raw;
  ev_view_t        ev_view [N_EV];

  // Named internal events for assertions
  logic a_tick_req, a_dir_valid, a_dir_down;
  logic b_restart_req, b_updn_on, b_dir_down;
  logic tick_pre;

  assign ev_raw = {ev_b_in, ev_a_in};

  generate
    for (genvar ch = 0; ch < N_EV; ch++) begin : g_chan
      evact_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ev_raw[ch]),
        .view     (ev_view[ch])
      );
    end
  endgenerate

  evact_decode_a i_dec_a (
    .clk        (clk),
    .rst_n      (rst_n),
    .code       (act_a_sel),
    .ev         (ev_view[CH_A]),
    .presc_tick (presc_tick),
    .tick_req   (a_tick_req),
    .dir_valid  (a_dir_valid),
    .dir_down   (a_dir_down)
  );

  evact_decode_b i_dec_b (
    .clk         (clk),
    .rst_n       (rst_n),
    .code        (act_b_sel),
    .ev          (ev_view[CH_B]),
    .restart_req (b_restart_req),
    .updn_on     (b_updn_on),
    .dir_down    (b_dir_down)
  );

  // Secondary up/down mode takes the tick source and the direction
  always_comb begin
    tick_pre = b_updn_on ? presc_tick : a_tick_req;
    if (b_updn_on)        cnt_down = b_dir_down;
    else if (a_dir_valid) cnt_down = a_dir_down;
    else                  cnt_down = 1'b0;
  end

  assign cnt_restart = b_restart_req & rst_n;
  assign cnt_tick    = resolve_tick(tick_pre, b_restart_req) & rst_n;

  assert_restart_blocks_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_restart |-> !cnt_tick);
  assert_b_dir_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_b_sel == B_UPDOWN) |-> (cnt_down == ev_view[CH_B].level));
  assert_dir_up_default_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_b_sel != B_UPDOWN && act_a_sel != A_UPDOWN) |-> !cnt_down);
  assert_updn_a_passes_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (act_a_sel == A_UPDOWN && !b_restart_req && !b_updn_on) |-> (cnt_tick == presc_tick));

endmodule

// File: tb/test_evact_unit.sv
module test_evact_unit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_a_in = 1'b0;
  logic       ev_b_in = 1'b0;
  logic       presc_tick = 1'b0;
  logic [1:0] act_a_sel = 2'd0;
  logic [2:0] act_b_sel = 3'd0;
  logic       cnt_tick, cnt_down, cnt_restart;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;  // 50 MHz

  evact_unit i_evact_unit (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_a_in     (ev_a_in),
    .ev_b_in     (ev_b_in),
    .presc_tick  (presc_tick),
    .act_a_sel   (act_a_sel),
    .act_b_sel   (act_b_sel),
    .cnt_tick    (cnt_tick),
    .cnt_down    (cnt_down),
    .cnt_restart (cnt_restart)
  );

  // Vector: [14:11] req, [10:9] a, [8:6] b, [5] ev_a, [4] ev_b, [3] presc,
  //         [2] tick, [1] down, [0] restart  (settled levels, no edges)
  localparam int NV = 16;
  localparam logic [14:0] VEC [NV] = '{
    {4'd4,  2'd2, 3'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R4 gate open
    {4'd4,  2'd2, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R4 gate closed
    {4'd4,  2'd2, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 no tick
    {4'd5,  2'd3, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R5 up
    {4'd5,  2'd3, 3'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}, // R5 down
    {4'd5,  2'd3, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R5 no tick
    {4'd6,  2'd0, 3'd3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}, // R6 over rise code
    {4'd6,  2'd2, 3'd3, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R6 up
    {4'd6,  2'd3, 3'd3, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R6 B wins dir
    {4'd9,  2'd0, 3'd6, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}, // R9 hold
    {4'd11, 2'd3, 3'd6, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}, // R11 restart beats tick
    {4'd9,  2'd3, 3'd6, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R9 released
    {4'd10, 2'd2, 3'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R10 code 1
    {4'd10, 2'd2, 3'd2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R10 code 2
    {4'd10, 2'd2, 3'd7, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R10 code 7
    {4'd2,  2'd0, 3'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}  // R2 steady level
  };

  task automatic step();
    @(posedge clk);
    #5;
  endtask

  task automatic settle();
    repeat (3) step();
  endtask

  task automatic check(input string req, input logic got, input logic exp, input string what);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic idle(input logic [1:0] a, input logic [2:0] b);
    act_a_sel = a; act_b_sel = b;
    ev_a_in = 1'b0; ev_b_in = 1'b0; presc_tick = 1'b0;
    settle();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R12: reset holds outputs low even with an up/down code and a tick
    act_a_sel = 2'd3; act_b_sel = 3'd6; ev_b_in = 1'b1; presc_tick = 1'b1;
    repeat (3) step();
    check("R12", cnt_tick, 1'b0, "tick in reset");
    check("R12", cnt_restart, 1'b0, "restart in reset");
    ev_b_in = 1'b0; presc_tick = 1'b0;
    rst_n = 1'b1;
    step();
    check("R12", cnt_restart, 1'b0, "cleared sync after reset");

    // Table walk over level-driven actions
    for (int i = 0; i < NV; i++) begin
      act_a_sel  = VEC[i][10:9];
      act_b_sel  = VEC[i][8:6];
      ev_a_in    = VEC[i][5];
      ev_b_in    = VEC[i][4];
      presc_tick = 1'b0;
      settle();
      presc_tick = VEC[i][3];
      #1;
      n_checks++;
      if ({cnt_tick, cnt_down, cnt_restart} !== VEC[i][2:0]) begin
        n_fail++;
        $display("FAIL vector %0d R%0d: actual tick/down/rst %b expected %b",
                 i, VEC[i][14:11], {cnt_tick, cnt_down, cnt_restart}, VEC[i][2:0]);
      end
      presc_tick = 1'b0;
    end

    // R1 latency and R2 rise counting
    idle(2'd0, 3'd0);
    ev_a_in = 1'b1;
    step(); check("R1", cnt_tick, 1'b0, "after one edge");
    step(); check("R2", cnt_tick, 1'b1, "rise strobe");
    step(); check("R1", cnt_tick, 1'b0, "strobe width");
    ev_a_in = 1'b0;
    step(); step(); check("R2", cnt_tick, 1'b0, "falling edge ignored");

    // R3 any-edge counting
    idle(2'd1, 3'd0);
    ev_a_in = 1'b1;
    step(); step(); check("R3", cnt_tick, 1'b1, "rise counted");
    step(); check("R3", cnt_tick, 1'b0, "rise strobe width");
    ev_a_in = 1'b0;
    step(); step(); check("R3", cnt_tick, 1'b1, "fall counted");
    step(); check("R3", cnt_tick, 1'b0, "fall strobe width");

    // R7 restart on rising edge only
    idle(2'd0, 3'd4);
    ev_b_in = 1'b1;
    step(); check("R7", cnt_restart, 1'b0, "before latency");
    step(); check("R7", cnt_restart, 1'b1, "rise restart");
    step(); check("R7", cnt_restart, 1'b0, "restart width");
    ev_b_in = 1'b0;
    step(); step(); check("R7", cnt_restart, 1'b0, "fall ignored");

    // R8 restart on any edge
    idle(2'd0, 3'd5);
    ev_b_in = 1'b1;
    step(); step(); check("R8", cnt_restart, 1'b1, "rise restart");
    ev_b_in = 1'b0;
    step(); step(); check("R8", cnt_restart, 1'b1, "fall restart");
    step(); check("R8", cnt_restart, 1'b0, "restart width");

    // R9 hold for many cycles
    idle(2'd0, 3'd6);
    ev_b_in = 1'b1;
    repeat (6) step();
    check("R9", cnt_restart, 1'b1, "held restart");
    ev_b_in = 1'b0;
    step(); check("R9", cnt_restart, 1'b1, "still in sync chain");
    step(); check("R9", cnt_restart, 1'b0, "released");

    // R10 unused and none codes ignore edges on the second line
    for (int c = 0; c < 8; c++) begin
      if (c == 0 || c == 1 || c == 2 || c == 7) begin
        idle(2'd0, 3'(c));
        ev_b_in = 1'b1;
        step(); step(); check("R10", cnt_restart, 1'b0, "rise on unused code");
        ev_b_in = 1'b0;
        step(); step(); check("R10", cnt_restart, 1'b0, "fall on unused code");
      end
    end

    // R11 simultaneous count edge and restart edge
    idle(2'd0, 3'd4);
    ev_a_in = 1'b1; ev_b_in = 1'b1;
    step(); step();
    check("R11", cnt_restart, 1'b1, "restart present");
    check("R11", cnt_tick, 1'b0, "tick suppressed");

    // R6 direction is up outside up/down modes
    idle(2'd2, 3'd0);
    ev_a_in = 1'b1; ev_b_in = 1'b1;
    settle();
    check("R6", cnt_down, 1'b0, "default up");

    finish_run();
  end

endmodule